// File: doc/BRIEF.md
# Nibble-Loaded Cycle Interrupt Timer

This block is the interrupt timer of a cartridge bank-switching controller that sits on an 8-bit CPU bus. It holds a 16-bit up-counter that advances once per CPU bus cycle. When the counter rolls over from $FFFF it raises an active-low interrupt request, provided the interrupt is armed. Software presets the counter one nibble at a time, arms the interrupt through a separate register slot, and acknowledges a pending request through a third slot.

Register slots are chosen by CPU address bits A14..A12 inside the cartridge ROM window ($8000-$FFFF, /ROMSEL low). Only CPU writes count. The block runs on a fast synchronous clock. It samples the CPU's M2 phase signal and treats each falling edge of M2 as the end of one CPU cycle. On that edge the bus write is taken and the counter steps. Firing the interrupt disarms it, so software must re-arm it after each event.

Top module: `cyc_irq_timer`

## Requirements
- R1: A register write is taken only on an M2 falling edge with romsel_ni = 0 and rw_i = 0. A cycle with rw_i = 1, or with romsel_ni = 1, changes no register and acts as a plain counting cycle.
- R2: A write to slot n (addr_hi_i = n, n = 0..3, meaning CPU $8000/$9000/$A000/$B000) loads counter bits [4n+3:4n] from dat_i[3:0]. The other three nibbles keep their values. The counter does not step in that cycle.
- R3: On every other M2 falling edge the counter steps by one, whether the interrupt is armed or not.
- R4: Stepping from $FFFF wraps the counter to $0000, and counting continues from there. There is no reload.
- R5: A wrap that happens while the interrupt is armed sets the pending flag. irq_no then reads 0 from the next clock on.
- R6: A wrap that fires the interrupt also disarms it. A later wrap without a fresh arm leaves irq_no at 1.
- R7: A write to slot 4 (CPU $C000) sets the arm bit from dat_i[1]: $F arms, $0 disarms, and $1 leaves it disarmed. If this write happens in the same cycle as a wrap, the wrap is judged against the previous arm state and the written value is kept.
- R8: A write to slot 5 (CPU $D000) clears the pending flag for any data value. A wrap that fires in the same cycle takes precedence.
- R9: An active reset clears the pending flag, the arm bit and the counter, and drives irq_no to 1.
- R10: Writes to slots 6 and 7 ($E000, $F000) change no timer state. They count as ordinary counting cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast synchronous clock that samples the CPU bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m2_i | input | 1 | CPU M2 phase; a falling edge ends one CPU cycle |
| romsel_ni | input | 1 | Cartridge ROM window select, active low |
| rw_i | input | 1 | CPU read (1) / write (0) |
| addr_hi_i | input | 3 | CPU address bits A14..A12, register slot number |
| dat_i | input | 4 | CPU data bits D3..D0 |
| irq_no | output | 1 | Interrupt request, active low (open-drain style) |

## Verification
Counter preloads close to $FFFF are followed by a known number of idle cycles. The cycle in which irq_no falls then shows whether load cycles are kept from stepping and whether a nibble written alone leaves its neighbours intact. Read cycles, writes with /ROMSEL high, and writes to the spare slots are placed just before a wrap. If they were wrongly decoded as loads, the interrupt would move or disappear. Arm patterns $F, $1 and $F followed by $0 show that only data bit 1 arms the timer. A second wrap without re-arming shows that the enable clears by itself. Pending-flag acknowledges use data values 0 and $F.

// File: rtl/cyc_irq_pkg.sv
`timescale 1ns/1ps
package cyc_irq_pkg;
  localparam int unsigned SLOT_W = 3;   // A14..A12
  localparam int unsigned NIB_N  = 4;   // counter nibbles, slots 0..3

  typedef enum logic [SLOT_W-1:0] {
    SLOT_NIB0  = 3'd0,
    SLOT_NIB1  = 3'd1,
    SLOT_NIB2  = 3'd2,
    SLOT_NIB3  = 3'd3,
    SLOT_ARM   = 3'd4,
    SLOT_ACK   = 3'd5,
    SLOT_SPARE6 = 3'd6,
    SLOT_SPARE7 = 3'd7
  } slot_e;
endpackage

// File: rtl/cyc_irq_bus_dec.sv
`timescale 1ns/1ps
module cyc_irq_bus_dec
  import cyc_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 m2_i,
  input  logic                 romsel_ni,
  input  logic                 rw_i,
  input  logic [SLOT_W-1:0]    addr_hi_i,
  output logic                 tick_o,
  output logic [NIB_N-1:0]     nib_ld_o,
  output logic                 arm_wr_o,
  output logic                 ack_o
);
  logic  m2_q;
  logic  wr;
  slot_e slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  // end of CPU cycle
  assign tick_o = m2_q & ~m2_i;
  assign wr     = tick_o & ~romsel_ni & ~rw_i;
  assign slot   = slot_e'(addr_hi_i);

  for (genvar g = 0; g < NIB_N; g++) begin : g_ld
    assign nib_ld_o[g] = wr && (slot == slot_e'(g));
  end

  assign arm_wr_o = wr && (slot == SLOT_ARM);
  assign ack_o    = wr && (slot == SLOT_ACK);
endmodule

// File: rtl/cyc_irq_count.sv
`timescale 1ns/1ps
module cyc_irq_count
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NIB_W = CNT_W / NIB_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NIB_N-1:0]  nib_ld_i,
  input  logic [NIB_W-1:0]  dat_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic [NIB_W-1:0] nib_q [NIB_N];
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  for (genvar g = 0; g < NIB_N; g++) begin : g_pack
    assign cnt_o[g*NIB_W +: NIB_W] = nib_q[g];
  end

  // a load cycle freezes stepping
  assign step    = tick_i & ~|nib_ld_i;
  assign cnt_nxt = cnt_o + CNT_W'(1);
  assign wrap_o  = step & (&cnt_o);

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          nib_q[g] <= '0;
      else if (nib_ld_i[g]) nib_q[g] <= dat_i;
      else if (step)        nib_q[g] <= cnt_nxt[g*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/cyc_irq_flag.sv
`timescale 1ns/1ps
module cyc_irq_flag #(
  parameter int unsigned DAT_W  = 4,
  parameter int unsigned ARM_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             arm_wr_i,
  input  logic             ack_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic             arm_o,
  output logic             pend_o
);
  logic fire;

  assign fire = wrap_i & arm_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      // explicit arm write outranks self-disarm
      if (arm_wr_i)  arm_o <= dat_i[ARM_BIT];
      else if (fire) arm_o <= 1'b0;
      // a new event outranks acknowledge
      if (fire)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
`timescale 1ns/1ps
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ARM_BIT = 1,
  localparam int unsigned NIB_W  = CNT_W / NIB_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic              romsel_ni,
  input  logic              rw_i,
  input  logic [SLOT_W-1:0] addr_hi_i,
  input  logic [NIB_W-1:0]  dat_i,
  output logic              irq_no
);
  logic             tick;
  logic [NIB_N-1:0] nib_ld;
  logic             arm_wr;
  logic             ack;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             arm;
  logic             pend;

  cyc_irq_bus_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .m2_i      (m2_i),
    .romsel_ni (romsel_ni),
    .rw_i      (rw_i),
    .addr_hi_i (addr_hi_i),
    .tick_o    (tick),
    .nib_ld_o  (nib_ld),
    .arm_wr_o  (arm_wr),
    .ack_o     (ack)
  );

  cyc_irq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .nib_ld_i (nib_ld),
    .dat_i    (dat_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  cyc_irq_flag #(.DAT_W(NIB_W), .ARM_BIT(ARM_BIT)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .arm_wr_i (arm_wr),
    .ack_i    (ack),
    .dat_i    (dat_i),
    .arm_o    (arm),
    .pend_o   (pend)
  );

  assign irq_no = ~pend;
endmodule

// File: rtl/cyc_irq_timer_chk.sv
`timescale 1ns/1ps
module cyc_irq_timer_chk
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ARM_BIT = 1,
  localparam int unsigned NIB_W  = CNT_W / NIB_N
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [NIB_N-1:0] nib_ld_i,
  input logic [NIB_W-1:0] dat_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wrap_i,
  input logic             arm_wr_i,
  input logic             ack_i,
  input logic             arm_i,
  input logic             pend_i,
  input logic             irq_ni
);
  assert_nib0_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_ld_i[0] |=> cnt_i[NIB_W-1:0] == $past(dat_i));

  assert_nib3_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_ld_i[NIB_N-1] |=> cnt_i[CNT_W-1 -: NIB_W] == $past(dat_i));

  assert_hold_between_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> cnt_i == '0);

  assert_fire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && arm_i) |=> (pend_i && !irq_ni));

  assert_self_disarm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && arm_i && !arm_wr_i) |=> !arm_i);

  assert_no_fire_disarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !pend_i) |=> !pend_i);

  assert_arm_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_wr_i |=> arm_i == $past(dat_i[ARM_BIT]));

  assert_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(wrap_i && arm_i)) |=> !pend_i);

  assert_reset_state_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!pend_i && !arm_i && irq_ni && cnt_i == '0));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W), .ARM_BIT(ARM_BIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick),
  .nib_ld_i (nib_ld),
  .dat_i    (dat_i),
  .cnt_i    (cnt),
  .wrap_i   (wrap),
  .arm_wr_i (arm_wr),
  .ack_i    (ack),
  .arm_i    (arm),
  .pend_i   (pend),
  .irq_ni   (irq_no)
);

// File: tb/cyc_irq_timer_test.sv
`timescale 1ns/1ps
module cyc_irq_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       m2 = 1'b0;
  logic       romsel_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] dat = '0;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string phase = "R9";

  always #2 clk = ~clk;

  cyc_irq_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .m2_i(m2), .romsel_ni(romsel_n),
    .rw_i(rw), .addr_hi_i(addr), .dat_i(dat), .irq_no(irq_n)
  );

  // behavioural reference
  int unsigned m_cnt;
  bit m_arm, m_pend, m_m2;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_arm = 0; m_pend = 0; m_m2 = 0;
    end else begin
      if (m_m2 && !m2) begin
        bit is_wr, fired;
        is_wr = !romsel_n && !rw;
        fired = 0;
        if (is_wr && addr < 3'd4) begin
          int unsigned sh;
          sh = 4 * int'(addr);
          m_cnt = (m_cnt & ~(32'hF << sh)) | (32'(dat) << sh);
        end else begin
          if (m_cnt == 65535) begin
            m_cnt = 0;
            fired = m_arm;
          end else m_cnt = m_cnt + 1;
        end
        if (fired) begin m_arm = 0; m_pend = 1; end
        if (is_wr && addr == 3'd4) m_arm = dat[1];
        if (is_wr && addr == 3'd5 && !fired) m_pend = 0;
      end
      m_m2 = m2;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      total++;
      if (irq_n !== !m_pend) begin
        bad++;
        $display("FAIL %s model compare: irq_n=%b expected %b", phase, irq_n, !m_pend);
      end
    end
  end

  task automatic chk(input logic exp, input string tag);
    total++;
    if (irq_n !== exp) begin
      bad++;
      $display("FAIL %s: irq_n=%b expected %b", tag, irq_n, exp);
    end
  endtask

  task automatic cyc(input logic rs, input logic wr_n, input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    romsel_n = rs; rw = wr_n; addr = a; dat = d; m2 = 1'b1;
    repeat (3) @(negedge clk);
    m2 = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    cyc(1'b0, 1'b0, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 3'd0, 4'h0);
  endtask

  task automatic load16(input logic [15:0] v);
    for (int i = 0; i < 4; i++) wr(3'(i), v[4*i +: 4]);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b1, "R9 reset");
    rst_ni = 1'b1;

    phase = "R5";
    wr(3'd4, 4'hF);
    load16(16'hFFFF);
    chk(1'b1, "R2 loads do not step");
    idle(1);
    chk(1'b0, "R5 fire on wrap");

    phase = "R6";
    wr(3'd5, 4'h0);                       // count 0001
    chk(1'b1, "R8 ack data 0");
    for (int i = 1; i < 4; i++) wr(3'(i), 4'hF);  // FFF1
    idle(14);
    chk(1'b1, "R3 counts while disarmed");
    idle(1);
    chk(1'b1, "R6 no refire without arm");

    phase = "R4";
    wr(3'd4, 4'hF);                       // 0001
    for (int i = 1; i < 4; i++) wr(3'(i), 4'hF);  // FFF1
    idle(14);
    chk(1'b1, "R4 one step before wrap");
    idle(1);
    chk(1'b0, "R4 wrapped value kept counting");

    phase = "R7";
    wr(3'd5, 4'hF);
    chk(1'b1, "R8 ack data F");
    wr(3'd4, 4'h1);
    load16(16'hFFFF);
    idle(1);
    chk(1'b1, "R7 bit0 alone does not arm");
    wr(3'd4, 4'hF);
    wr(3'd4, 4'h0);
    load16(16'hFFFF);
    idle(1);
    chk(1'b1, "R7 F then 0 disarms");

    phase = "R1";
    wr(3'd4, 4'hF);
    load16(16'hFFFF);
    cyc(1'b0, 1'b1, 3'd3, 4'h0);
    chk(1'b0, "R1 read cycle not a load");
    wr(3'd5, 4'h0);
    wr(3'd4, 4'hF);
    load16(16'hFFFF);
    cyc(1'b1, 1'b0, 3'd3, 4'h0);
    chk(1'b0, "R1 write outside window not a load");
    wr(3'd5, 4'h0);
    chk(1'b1, "R8 ack after R1");

    phase = "R10";
    wr(3'd4, 4'hF);
    load16(16'hFFFE);
    wr(3'd6, 4'h0);
    chk(1'b1, "R10 slot 6 steps only");
    wr(3'd7, 4'h0);
    chk(1'b0, "R10 slot 7 steps into wrap");
    wr(3'd5, 4'h0);

    phase = "R2";
    wr(3'd4, 4'hF);
    load16(16'hFFFF);
    wr(3'd0, 4'h0);                       // FFF0
    idle(15);
    chk(1'b1, "R2 upper nibbles kept");
    idle(1);
    chk(1'b0, "R2 fire after 16 steps");

    phase = "R9";
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(1'b1, "R9 reset clears pending");
    rst_ni = 1'b1;
    load16(16'hFFFF);
    idle(1);
    chk(1'b1, "R9 reset clears arm");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule